// File: doc/BRIEF.md
# Partitioned Four-Way LRU Replacement

This block keeps the recency and validity state of a four-way set-associative cache and names the way that should be replaced when a cacheable miss allocates. Each set holds a 2-bit age for every way, and the four ages form a ranking from 0 (least recent) to 3 (most recent). It also holds one valid bit per way. Tag and data arrays sit outside the block. The cache controller presents a set index and an access type. It reads back the victim way and a flag saying whether this access type may allocate at all. It then reports hits and allocations on the same set index.

A 3-bit sharing code picks how the ways are split. In one setting all four ways form one pool. In two other settings, instruction fetches and data references replace only inside their own group of ways, and each group keeps its own LRU order. The code can change at run time. The stored rankings are kept when it does, so the next victim is simply the least-recent way of the newly allowed group. Separate enables stop instruction fetches or data references from allocating. A 4-bit invalidate mask drops chosen ways from every set in one cycle.

Top module: `part_lru`

## Requirements
- R1: After reset every way of every set is invalid, so with both enables high the victim is way 0 and the allocate flag is 1 for either access type in any set.
- R2: With sharing code 3'b000 all four ways form one pool per set. Once every way is valid, the victim is the way touched least recently by a hit or an accepted allocate.
- R3: With sharing code 3'b010, instruction fetches (type input 0) choose only among ways 0 and 1, and data references (type input 1) choose only among ways 2 and 3. Each group is ordered by its own recency.
- R4: With sharing code 3'b011, instruction fetches choose only among ways 0, 1 and 2, and data references always get way 3.
- R5: Sharing codes 3'b001 and 3'b1xx give the same victim as 3'b000.
- R6: When the instruction enable is low, instruction fetches show an allocate flag of 0. When the data enable is low, data references show an allocate flag of 0. An allocate strobe that is not allowed leaves both the valid bits and the recency unchanged.
- R7: Inside the allowed group, an invalid way is picked before any valid way, and among invalid ways the lowest number wins. An accepted allocate marks its way valid.
- R8: A hit or an accepted allocate makes its way the most recent in the set. Only ways that were more recent than it move down by one place, so the relative order of the other ways is kept.
- R9: Bit n of the invalidate mask clears the valid bit of way n in every set in one cycle. If an allocate of that way happens in the same cycle, the invalidate wins.
- R10: Changing the sharing code does not alter the stored recency. The victim follows the new group using the existing order.
- R11: If a hit and an accepted allocate come in the same cycle, only the allocated way is made most recent.
- R12: Way numbers on all ports are 2-bit binary values 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| share_mode_i | input | 3 | Way sharing code |
| icache_en_i | input | 1 | Instruction fetches may allocate |
| dcache_en_i | input | 1 | Data references may allocate |
| set_i | input | SET_W | Set index for lookup, hit and allocate |
| is_data_i | input | 1 | Access type: 0 instruction fetch, 1 data reference |
| hit_i | input | 1 | Hit strobe for way hit_way_i |
| hit_way_i | input | 2 | Way that hit |
| alloc_i | input | 1 | Allocate strobe for way alloc_way_i |
| alloc_way_i | input | 2 | Way being filled |
| inval_mask_i | input | 4 | Per-way invalidate, applied to all sets |
| victim_way_o | output | 2 | Way to replace for the presented set and type |
| alloc_ok_o | output | 1 | Presented access type may allocate |

## Verification
The set that is filled in order and then hit in mixed order, including a hit on a middle-aged way, separates true LRU from FIFO. It also separates LRU from a scheme in which every way ages on each touch. With one fixed recency order, the same set is then read back under each sharing code and both access types, which shows whether the group masks are right and that a code change does not disturb the order. The reserved codes are read back in a state where the split modes would give a different answer. Blocked allocates, invalidates that overlap an allocate, and a hit that arrives together with an allocate are each set up so that the wrong priority leads to a different victim.

// File: rtl/part_lru_pkg.sv
package part_lru_pkg;

    localparam int NUM_WAYS = 4;

    typedef logic [1:0] way_t;
    typedef logic [1:0] age_t;
    typedef age_t [NUM_WAYS-1:0] age_vec_t;

    typedef enum logic [1:0] {
        SHARE_ALL,
        SPLIT_TWO_TWO,
        SPLIT_THREE_ONE
    } share_e;

    function automatic share_e decode_share(input logic [2:0] code);
        share_e r;
        case (code)
            3'b010:  r = SPLIT_TWO_TWO;
            3'b011:  r = SPLIT_THREE_ONE;
            default: r = SHARE_ALL;
        endcase
        return r;
    endfunction

    function automatic logic is_ranking(input age_vec_t ages);
        logic [NUM_WAYS-1:0] seen;
        seen = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            seen[ages[w]] = 1'b1;
        end
        return (seen == {NUM_WAYS{1'b1}});
    endfunction

endpackage

// File: rtl/part_lru_group_mask.sv
module part_lru_group_mask
    import part_lru_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          share_mode_i,
    input  logic                is_data_i,
    input  logic                icache_en_i,
    input  logic                dcache_en_i,
    output logic [NUM_WAYS-1:0] allowed_o,
    output logic                alloc_ok_o
);

    share_e share;

    always_comb begin
        share = decode_share(share_mode_i);
        case (share)
            SPLIT_TWO_TWO:   allowed_o = is_data_i ? 4'b1100 : 4'b0011;
            SPLIT_THREE_ONE: allowed_o = is_data_i ? 4'b1000 : 4'b0111;
            default:         allowed_o = 4'b1111;
        endcase
        alloc_ok_o = is_data_i ? dcache_en_i : icache_en_i;
    end

    // R5: reserved codes open the whole set
    assert_reserved_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (share_mode_i[2] || share_mode_i == 3'b001) |-> (allowed_o == 4'b1111));

    assert_split_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (share_mode_i == 3'b010) |-> ($countones(allowed_o) == 2));

    assert_split_uneven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (share_mode_i == 3'b011) |-> ($countones(allowed_o) == (is_data_i ? 1 : 3)));

endmodule

// File: rtl/part_lru_victim_pick.sv
module part_lru_victim_pick
    import part_lru_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_WAYS-1:0] allowed_i,
    input  logic [NUM_WAYS-1:0] valid_i,
    input  age_vec_t            age_i,
    output way_t                victim_o
);

    logic [NUM_WAYS-1:0] free;
    logic                found;
    age_t                best_age;
    way_t                best_way;
    way_t                free_way;

    always_comb begin
        free     = allowed_i & ~valid_i;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (free[w]) free_way = way_t'(w);
        end

        found    = 1'b0;
        best_age = '0;
        best_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (allowed_i[w] && (!found || age_i[w] < best_age)) begin
                found    = 1'b1;
                best_age = age_i[w];
                best_way = way_t'(w);
            end
        end

        victim_o = (|free) ? free_way : best_way;
    end

    assert_victim_in_group_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (allowed_i != '0) |-> allowed_i[victim_o]);

    assert_free_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(allowed_i & ~valid_i)) |-> !valid_i[victim_o]);

    assert_oldest_chosen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((allowed_i & ~valid_i) == '0 && allowed_i == 4'b1111) |-> (age_i[victim_o] == 2'd0));

endmodule

// File: rtl/part_lru_age_update.sv
module part_lru_age_update
    import part_lru_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  way_t     touch_way_i,
    input  age_vec_t age_i,
    output age_vec_t age_o
);

    age_t touched_age;

    always_comb begin
        touched_age = age_i[touch_way_i];
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (way_t'(w) == touch_way_i) begin
                age_o[w] = age_t'(NUM_WAYS - 1);
            end else if (age_i[w] > touched_age) begin
                age_o[w] = age_i[w] - 2'd1;
            end else begin
                age_o[w] = age_i[w];
            end
        end
    end

    // R8: moving one way to the top keeps a full ranking
    assert_rank_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ranking(age_i) |-> is_ranking(age_o));

endmodule

// File: rtl/part_lru.sv
module part_lru
    import part_lru_pkg::*;
#(
    parameter int NUM_SETS = 16,
    localparam int SET_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       share_mode_i,
    input  logic             icache_en_i,
    input  logic             dcache_en_i,
    input  logic [SET_W-1:0] set_i,
    input  logic             is_data_i,
    input  logic             hit_i,
    input  logic [1:0]       hit_way_i,
    input  logic             alloc_i,
    input  logic [1:0]       alloc_way_i,
    input  logic [3:0]       inval_mask_i,
    output logic [1:0]       victim_way_o,
    output logic             alloc_ok_o
);

    typedef struct packed {
        logic [NUM_SETS-1:0][NUM_WAYS-1:0] valid;
        age_vec_t [NUM_SETS-1:0]           age;
    } lru_state_t;

    lru_state_t st_d, st_q;

    logic [NUM_WAYS-1:0] allowed;
    logic                alloc_take;
    logic                touch;
    way_t                touch_way;
    age_vec_t            cur_age;
    age_vec_t            new_age;
    logic [NUM_WAYS-1:0] cur_valid;

    assign cur_age   = st_q.age[set_i];
    assign cur_valid = st_q.valid[set_i];

    part_lru_group_mask u_mask (
        .clk          (clk),
        .rst_n        (rst_n),
        .share_mode_i (share_mode_i),
        .is_data_i    (is_data_i),
        .icache_en_i  (icache_en_i),
        .dcache_en_i  (dcache_en_i),
        .allowed_o    (allowed),
        .alloc_ok_o   (alloc_ok_o)
    );

    part_lru_victim_pick u_pick (
        .clk       (clk),
        .rst_n     (rst_n),
        .allowed_i (allowed),
        .valid_i   (cur_valid),
        .age_i     (cur_age),
        .victim_o  (victim_way_o)
    );

    part_lru_age_update u_age (
        .clk         (clk),
        .rst_n       (rst_n),
        .touch_way_i (touch_way),
        .age_i       (cur_age),
        .age_o       (new_age)
    );

    always_comb begin
        st_d       = st_q;
        alloc_take = alloc_i && alloc_ok_o;
        touch      = alloc_take || hit_i;
        touch_way  = alloc_take ? alloc_way_i : hit_way_i;

        if (touch) begin
            st_d.age[set_i] = new_age;
        end
        if (alloc_take) begin
            st_d.valid[set_i][alloc_way_i] = 1'b1;
        end
        for (int s = 0; s < NUM_SETS; s++) begin
            st_d.valid[s] = st_d.valid[s] & ~inval_mask_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            for (int s = 0; s < NUM_SETS; s++) begin
                for (int w = 0; w < NUM_WAYS; w++) begin
                    st_q.age[s][w] <= age_t'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end

    assert_alloc_marks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && alloc_ok_o && !inval_mask_i[alloc_way_i])
        |=> st_q.valid[$past(set_i)][$past(alloc_way_i)]);

    assert_inval_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (inval_mask_i != '0) |=> ((cur_valid & $past(inval_mask_i)) == '0));

    assert_blocked_alloc_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !alloc_ok_o && !hit_i) |=> (st_q.age == $past(st_q.age)));

    assert_touch_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && alloc_ok_o) |=> (st_q.age[$past(set_i)][$past(alloc_way_i)] == 2'd3));

    assert_stored_rank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_ranking(cur_age));

endmodule

// File: tb/part_lru_bench.sv
module part_lru_bench;

    localparam int NS = 16;
    localparam int SW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    share_mode = 3'b000;
    logic          icache_en = 1'b1;
    logic          dcache_en = 1'b1;
    logic [SW-1:0] set_idx = '0;
    logic          is_data = 1'b1;
    logic          hit = 1'b0;
    logic [1:0]    hit_way = '0;
    logic          alloc = 1'b0;
    logic [1:0]    alloc_way = '0;
    logic [3:0]    inval_mask = '0;
    logic [1:0]    victim;
    logic          alloc_ok;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    part_lru #(.NUM_SETS(NS)) u_part_lru (
        .clk          (clk),
        .rst_n        (rst_n),
        .share_mode_i (share_mode),
        .icache_en_i  (icache_en),
        .dcache_en_i  (dcache_en),
        .set_i        (set_idx),
        .is_data_i    (is_data),
        .hit_i        (hit),
        .hit_way_i    (hit_way),
        .alloc_i      (alloc),
        .alloc_way_i  (alloc_way),
        .inval_mask_i (inval_mask),
        .victim_way_o (victim),
        .alloc_ok_o   (alloc_ok)
    );

    task automatic check_val(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock edge with the given strobes, strobes dropped at the next falling edge
    task automatic do_op(input int s, input logic d, input logic h, input int hw,
                         input logic a, input int aw, input logic [3:0] inv);
        @(negedge clk);
        set_idx = SW'(s); is_data = d;
        hit = h; hit_way = 2'(hw);
        alloc = a; alloc_way = 2'(aw);
        inval_mask = inv;
        @(negedge clk);
        hit = 1'b0; alloc = 1'b0; inval_mask = '0;
    endtask

    task automatic expect_victim(input string req, input int s, input logic d,
                                 input int exp_way, input int exp_ok);
        set_idx = SW'(s); is_data = d;
        #1;
        check_val(req, int'(victim), exp_way);
        check_val(req, int'(alloc_ok), exp_ok);
    endtask

    task automatic fill_set(input int s);
        for (int w = 0; w < 4; w++) begin
            expect_victim("R7 fill order", s, 1'b1, w, 1);
            do_op(s, 1'b1, 1'b0, 0, 1'b1, w, 4'b0000);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_victim("R1 reset set0 data", 0, 1'b1, 0, 1);
        expect_victim("R1 reset set5 instr", 5, 1'b0, 0, 1);
        expect_victim("R1 reset last set", NS - 1, 1'b1, 0, 1);
    endtask

    task automatic t_pool_lru();
        share_mode = 3'b000;
        fill_set(1);
        expect_victim("R2 oldest after fill", 1, 1'b1, 0, 1);
        do_op(1, 1'b1, 1'b1, 0, 1'b0, 0, 4'b0000);
        expect_victim("R2 hit way0", 1, 1'b1, 1, 1);
        do_op(1, 1'b1, 1'b1, 2, 1'b0, 0, 4'b0000);
        expect_victim("R2 hit way2", 1, 1'b1, 1, 1);
        do_op(1, 1'b1, 1'b0, 0, 1'b1, 1, 4'b0000);
        expect_victim("R2 refill way1", 1, 1'b1, 3, 1);
        do_op(1, 1'b1, 1'b1, 3, 1'b0, 0, 4'b0000);
        expect_victim("R8 hit way3", 1, 1'b1, 0, 1);
        do_op(1, 1'b1, 1'b1, 2, 1'b0, 0, 4'b0000);
        expect_victim("R8 middle hit", 1, 1'b1, 0, 1);
        do_op(1, 1'b1, 1'b1, 0, 1'b0, 0, 4'b0000);
        expect_victim("R8 order kept", 1, 1'b1, 1, 1);
    endtask

    // set 1 order oldest to newest: 1,3,2,0
    task automatic t_split_modes();
        @(negedge clk); share_mode = 3'b010;
        expect_victim("R3 instr group", 1, 1'b0, 1, 1);
        expect_victim("R3 data group", 1, 1'b1, 3, 1);
        @(negedge clk); share_mode = 3'b011;
        expect_victim("R4 instr group", 1, 1'b0, 1, 1);
        expect_victim("R4 data only way3", 1, 1'b1, 3, 1);
        @(negedge clk); share_mode = 3'b000;
        expect_victim("R10 back to pool", 1, 1'b1, 1, 1);
        @(negedge clk); share_mode = 3'b010;
        do_op(1, 1'b1, 1'b0, 0, 1'b1, 3, 4'b0000);
        expect_victim("R3 data group after fill", 1, 1'b1, 2, 1);
        expect_victim("R10 instr untouched", 1, 1'b0, 1, 1);
        @(negedge clk); share_mode = 3'b011;
        expect_victim("R4 data still way3", 1, 1'b1, 3, 1);
    endtask

    // set 1 order: 1,2,0,3
    task automatic t_reserved();
        logic [2:0] codes [5] = '{3'b001, 3'b100, 3'b101, 3'b110, 3'b111};
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); share_mode = codes[i];
            expect_victim("R5 reserved data", 1, 1'b1, 1, 1);
            expect_victim("R5 reserved instr", 1, 1'b0, 1, 1);
        end
        @(negedge clk); share_mode = 3'b000;
    endtask

    task automatic t_enables();
        @(negedge clk); dcache_en = 1'b0;
        expect_victim("R6 data blocked", 2, 1'b1, 0, 0);
        expect_victim("R6 instr still open", 2, 1'b0, 0, 1);
        do_op(2, 1'b1, 1'b0, 0, 1'b1, 0, 4'b0000);
        do_op(1, 1'b1, 1'b0, 0, 1'b1, 1, 4'b0000);
        @(negedge clk); dcache_en = 1'b1;
        expect_victim("R6 blocked alloc not valid", 2, 1'b1, 0, 1);
        expect_victim("R6 blocked alloc no recency", 1, 1'b1, 1, 1);
        @(negedge clk); icache_en = 1'b0;
        expect_victim("R6 instr blocked", 2, 1'b0, 0, 0);
        do_op(2, 1'b0, 1'b0, 0, 1'b1, 0, 4'b0000);
        @(negedge clk); icache_en = 1'b1;
        expect_victim("R6 instr alloc ignored", 2, 1'b0, 0, 1);
    endtask

    task automatic t_invalidate();
        fill_set(3);
        expect_victim("R2 set3 full", 3, 1'b1, 0, 1);
        do_op(0, 1'b1, 1'b0, 0, 1'b0, 0, 4'b1010);
        expect_victim("R9 set1 lowest free", 1, 1'b1, 1, 1);
        expect_victim("R9 set3 lowest free", 3, 1'b1, 1, 1);
        do_op(1, 1'b1, 1'b0, 0, 1'b1, 1, 4'b0010);
        expect_victim("R9 invalidate beats alloc", 1, 1'b1, 1, 1);
        do_op(1, 1'b1, 1'b0, 0, 1'b1, 1, 4'b0000);
        expect_victim("R7 next free way", 1, 1'b1, 3, 1);
    endtask

    task automatic t_hit_and_alloc();
        fill_set(4);
        do_op(4, 1'b1, 1'b1, 0, 1'b1, 1, 4'b0000);
        expect_victim("R11 alloc wins over hit", 4, 1'b1, 0, 1);
        @(negedge clk); dcache_en = 1'b0;
        do_op(4, 1'b1, 1'b1, 0, 1'b1, 2, 4'b0000);
        @(negedge clk); dcache_en = 1'b1;
        expect_victim("R11 blocked alloc leaves hit", 4, 1'b1, 2, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_pool_lru();
        t_split_modes();
        t_reserved();
        t_enables();
        t_invalidate();
        t_hit_and_alloc();
        check_val("R12 way range", int'(victim) < 4 ? 1 : 0, 1);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    end

endmodule